// File: doc/BRIEF.md
# Receive Frame-Sync Generator and Selector

This block produces the frame-synchronization strobe used by the receive side of a buffered serial port. A divider turns the system clock into a generated clock, `clkg`. A frame counter emits one frame pulse, `fsg`, every programmed number of generated-clock periods. In resync mode the programmed period is dropped. The generator then fires only when an active edge arrives on the external frame-sync pin, and that edge also restarts the divider so the generated clock re-aligns to it.

A source selector picks the internal receive frame sync from one of three places: the synchronized external pin, the generated pulse, or the transmit-side frame sync. The transmit-side source is used for loopback and clock-stop operation. The selector applies the polarity setting and drives the pin direction. The pin is driven only when the block generates its own frame sync in free-running mode. In every other mode it is left undriven.

All logic runs on one clock with a synchronous active-high reset. Every output is a register.

Top module: `rx_fsync_gen`

## Requirements
- R1: While `rst` is high, `fsg`, `rx_fs`, `rx_clk`, `fs_pin_out` and `fs_pin_oe` are 0 and `clkg` is 1.
- R2: `clkg` has a period of `clkg_div`+1 clocks. With `clkg_div`=3 it rises every 4 clocks.
- R3: With `resync_en`=0, the first `fsg` pulse is seen at the (`frame_per`+1)·(`clkg_div`+1)-th rising edge after reset is released. Later pulses follow at that same interval.
- R4: Each `fsg` pulse is high for exactly `clkg_div`+1 clocks, which is one generated-clock period.
- R5: With `resync_en`=1, `fsg` rises only after an active pin edge, and `frame_per` has no effect. The pulse is seen at the third rising edge after the pin reaches its active level. A pin held steady never fires again.
- R6: A resync event restarts the divider. `clkg` is high in the two clocks that start the pulse and low in the next two (`clkg_div`=3).
- R7: With `loopback_en`=0, `clk_stop[1]`=0 and `fs_internal_gen`=0, `rx_fs` equals the pin level after polarity correction, three edges after the pin changes. `fs_pin_oe` is 0.
- R8: With `fs_internal_gen`=1, `resync_en`=0, `loopback_en`=0 and `clk_stop[1]`=0, the following hold:
  - `fs_pin_oe` is 1.
  - `rx_fs` and `fs_pin_out` equal `fsg` delayed by one clock.
  - `fs_pin_out` is additionally XORed with `fs_pol_inv`.
- R9: With `fs_internal_gen`=1 and `resync_en`=1, `fs_pin_oe` is 0 and `rx_fs` follows `fsg` one clock later.
- R10: With `loopback_en`=1, whatever the value of `fs_internal_gen`, `rx_fs` equals `tx_fs` delayed by one clock and `fs_pin_oe` is 0.
- R11: With `clk_stop` equal to 2'b10 or 2'b11, the following hold:
  - `rx_clk` equals `tx_clk` one clock later.
  - `rx_fs` equals `tx_fs` one clock later.
  - `fs_pin_oe` is 0.

  With 2'b00 or 2'b01, `rx_clk` equals `clkg` one clock later.
- R12: `fs_pol_inv`=1 makes a low pin level active. A falling pin gives a high `rx_fs` in the input mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the clock that is divided |
| rst | input | 1 | Synchronous active-high reset |
| clkg_div | input | DIV_W | Divider value; generated clock period is this plus one |
| frame_per | input | PER_W | Frame period in generated-clock cycles, minus one |
| resync_en | input | 1 | 1: fire and re-align on pin edges only |
| fs_internal_gen | input | 1 | 1: receive frame sync comes from the generator |
| loopback_en | input | 1 | 1: receive frame sync taken from the transmit side |
| fs_pol_inv | input | 1 | 1: pin frame sync is active low |
| clk_stop | input | 2 | Bit 1 set routes the transmit clock and frame sync to the receiver |
| fs_pin_in | input | 1 | Frame-sync pin input value |
| tx_fs | input | 1 | Internal transmit frame sync |
| tx_clk | input | 1 | Internal transmit clock level |
| clkg | output | 1 | Generated clock level |
| fsg | output | 1 | Generated frame-sync pulse |
| rx_fs | output | 1 | Internal receive frame sync |
| rx_clk | output | 1 | Internal receive clock level |
| fs_pin_out | output | 1 | Value driven on the frame-sync pin |
| fs_pin_oe | output | 1 | Pin output enable; 0 means high impedance |

## Verification
The divider and frame counters are hidden. A wrong count shows within one frame as a first `fsg` rise at the wrong edge, a rise-to-rise interval that is off, or a pulse width other than one generated period. A stale synchronizer flop or a missed edge in resync mode appears three edges after the pin moves, either as an `fsg` that is missing or late or as one that fires with no edge. Source-select and direction faults show at the very next clock, on `rx_fs`, `rx_clk` and `fs_pin_oe`.

// File: rtl/rx_fsync_pkg.sv
package rx_fsync_pkg;
  typedef enum logic [1:0] {
    SRC_PIN = 2'd0,
    SRC_GEN = 2'd1,
    SRC_TX  = 2'd2
  } fs_src_e;
endpackage

// File: rtl/rxfs_pin_sync.sv
module rxfs_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic inv,
  output logic level,
  output logic edge_evt
);
  logic [STAGES:0] sh;
  logic            prev;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], pin};
  end

  // polarity-corrected synchronized level and its previous value
  assign level    = sh[STAGES-1] ^ inv;
  assign prev     = sh[STAGES] ^ inv;
  assign edge_evt = level & ~prev;
endmodule

// File: rtl/rxfs_clk_div.sv
module rxfs_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  input  logic             resync,
  output logic             clkg,
  output logic             tick
);
  logic [DIV_W-1:0] cnt, cnt_nxt;
  logic [DIV_W:0]   half;

  // high phase covers the first ceil((div+1)/2) counts
  assign half = ({1'b0, div} + 2) >> 1;

  always_comb begin
    if (resync)          cnt_nxt = '0;
    else if (cnt >= div) cnt_nxt = '0;
    else                 cnt_nxt = cnt + 1'b1;
  end

  // last count of a generated-clock period
  assign tick = (cnt >= div) && !resync;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      clkg <= 1'b1;
    end else begin
      cnt  <= cnt_nxt;
      clkg <= ({1'b0, cnt_nxt} < half);
    end
  end
endmodule

// File: rtl/rxfs_framer.sv
module rxfs_framer #(
  parameter int PER_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PER_W-1:0] per,
  input  logic             tick,
  input  logic             resync_mode,
  input  logic             ext_evt,
  output logic             fsg
);
  logic [PER_W-1:0] per_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      per_cnt <= per;
      fsg     <= 1'b0;
    end else if (resync_mode) begin
      if (ext_evt) begin
        fsg     <= 1'b1;
        per_cnt <= per;
      end else if (tick) begin
        fsg <= 1'b0;
      end
    end else if (tick) begin
      if (per_cnt == '0) begin
        fsg     <= 1'b1;
        per_cnt <= per;
      end else begin
        fsg     <= 1'b0;
        per_cnt <= per_cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/rxfs_route.sv
module rxfs_route
  import rx_fsync_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       loopback,
  input  logic [1:0] stop,
  input  logic       gen_sel,
  input  logic       resync_mode,
  input  logic       inv,
  input  logic       pin_level,
  input  logic       fsg,
  input  logic       clkg,
  input  logic       tx_fs,
  input  logic       tx_clk,
  output logic       rx_fs,
  output logic       rx_clk,
  output logic       pin_out,
  output logic       pin_oe
);
  fs_src_e src;
  logic    drive;

  always_comb begin
    if (stop[1] || loopback) src = SRC_TX;
    else if (gen_sel)        src = SRC_GEN;
    else                     src = SRC_PIN;
  end

  assign drive = (src == SRC_GEN) && !resync_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_fs   <= 1'b0;
      rx_clk  <= 1'b0;
      pin_out <= 1'b0;
      pin_oe  <= 1'b0;
    end else begin
      unique case (src)
        SRC_TX:  rx_fs <= tx_fs;
        SRC_GEN: rx_fs <= fsg;
        default: rx_fs <= pin_level;
      endcase
      rx_clk  <= stop[1] ? tx_clk : clkg;
      pin_oe  <= drive;
      pin_out <= drive ? (fsg ^ inv) : 1'b0;
    end
  end
endmodule

// File: rtl/rx_fsync_gen.sv
module rx_fsync_gen #(
  parameter int DIV_W       = 8,
  parameter int PER_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] clkg_div,
  input  logic [PER_W-1:0] frame_per,
  input  logic             resync_en,
  input  logic             fs_internal_gen,
  input  logic             loopback_en,
  input  logic             fs_pol_inv,
  input  logic [1:0]       clk_stop,
  input  logic             fs_pin_in,
  input  logic             tx_fs,
  input  logic             tx_clk,
  output logic             clkg,
  output logic             fsg,
  output logic             rx_fs,
  output logic             rx_clk,
  output logic             fs_pin_out,
  output logic             fs_pin_oe
);
  logic pin_level;
  logic ext_evt;
  logic resync;
  logic tick;

  rxfs_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin(fs_pin_in), .inv(fs_pol_inv),
    .level(pin_level), .edge_evt(ext_evt)
  );

  assign resync = resync_en && ext_evt;

  rxfs_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .div(clkg_div), .resync(resync),
    .clkg(clkg), .tick(tick)
  );

  rxfs_framer #(.PER_W(PER_W)) u_frm (
    .clk(clk), .rst(rst), .per(frame_per), .tick(tick),
    .resync_mode(resync_en), .ext_evt(ext_evt), .fsg(fsg)
  );

  rxfs_route u_route (
    .clk(clk), .rst(rst), .loopback(loopback_en), .stop(clk_stop),
    .gen_sel(fs_internal_gen), .resync_mode(resync_en), .inv(fs_pol_inv),
    .pin_level(pin_level), .fsg(fsg), .clkg(clkg), .tx_fs(tx_fs),
    .tx_clk(tx_clk), .rx_fs(rx_fs), .rx_clk(rx_clk),
    .pin_out(fs_pin_out), .pin_oe(fs_pin_oe)
  );
endmodule

// File: rtl/rx_fsync_gen_chk.sv
module rx_fsync_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic       resync_en,
  input logic       fs_internal_gen,
  input logic       loopback_en,
  input logic       fs_pol_inv,
  input logic [1:0] clk_stop,
  input logic       tx_fs,
  input logic       tx_clk,
  input logic       ext_evt,
  input logic       clkg,
  input logic       fsg,
  input logic       rx_fs,
  input logic       rx_clk,
  input logic       fs_pin_out,
  input logic       fs_pin_oe
);
  // R8
  oe_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (fs_pin_oe && !$past(rst)) |->
      $past(fs_internal_gen && !resync_en && !loopback_en && !clk_stop[1]));

  // R8
  pin_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (fs_pin_oe && !$past(rst)) |-> (fs_pin_out == ($past(fsg) ^ $past(fs_pol_inv))));

  // R5
  sync_fire_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(fsg) && $past(resync_en) && !$past(rst)) |-> $past(ext_evt));

  // R6
  realign_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(resync_en && ext_evt)) |-> (clkg && fsg));

  // R10
  loop_fs_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(loopback_en)) |-> (rx_fs == $past(tx_fs) && !fs_pin_oe));

  // R11
  stop_clk_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(clk_stop[1])) |-> (rx_clk == $past(tx_clk) && rx_fs == $past(tx_fs)));
endmodule

bind rx_fsync_gen rx_fsync_gen_chk u_chk (
  .clk(clk), .rst(rst), .resync_en(resync_en), .fs_internal_gen(fs_internal_gen),
  .loopback_en(loopback_en), .fs_pol_inv(fs_pol_inv), .clk_stop(clk_stop),
  .tx_fs(tx_fs), .tx_clk(tx_clk), .ext_evt(ext_evt), .clkg(clkg), .fsg(fsg),
  .rx_fs(rx_fs), .rx_clk(rx_clk), .fs_pin_out(fs_pin_out), .fs_pin_oe(fs_pin_oe)
);

// File: tb/rx_fsync_gen_bench.sv
module rx_fsync_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  clkg_div = 8'd3;
  logic [11:0] frame_per = 12'd4;
  logic        resync_en = 1'b0;
  logic        fs_internal_gen = 1'b0;
  logic        loopback_en = 1'b0;
  logic        fs_pol_inv = 1'b0;
  logic [1:0]  clk_stop = 2'b00;
  logic        fs_pin_in = 1'b0;
  logic        tx_fs = 1'b0;
  logic        tx_clk = 1'b0;
  logic        clkg, fsg, rx_fs, rx_clk, fs_pin_out, fs_pin_oe;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  rx_fsync_gen u_rx_fsync_gen (
    .clk(clk), .rst(rst), .clkg_div(clkg_div), .frame_per(frame_per),
    .resync_en(resync_en), .fs_internal_gen(fs_internal_gen),
    .loopback_en(loopback_en), .fs_pol_inv(fs_pol_inv), .clk_stop(clk_stop),
    .fs_pin_in(fs_pin_in), .tx_fs(tx_fs), .tx_clk(tx_clk), .clkg(clkg),
    .fsg(fsg), .rx_fs(rx_fs), .rx_clk(rx_clk), .fs_pin_out(fs_pin_out),
    .fs_pin_oe(fs_pin_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst = 1'b1;
    repeat (3) step();
    chk(fsg == 0 && rx_fs == 0 && rx_clk == 0, "R1 fsg/rx_fs/rx_clk", {fsg, rx_fs, rx_clk}, 0);
    chk(fs_pin_out == 0 && fs_pin_oe == 0, "R1 pin out/oe", {fs_pin_out, fs_pin_oe}, 0);
    chk(clkg == 1, "R1 clkg", clkg, 1);
  endtask

  task automatic t_free(input bit inv);
    int first = 0, second = 0, width = 0, last_rise = 0, bad_int = 0, bad_oe = 0, bad_fwd = 0;
    logic pf, pc;
    @(negedge clk);
    clkg_div = 8'd3; frame_per = 12'd4; resync_en = 0; fs_internal_gen = 1;
    loopback_en = 0; clk_stop = 2'b00; fs_pol_inv = inv;
    do_reset();
    pf = fsg; pc = clkg;
    for (int k = 1; k <= 60; k++) begin
      step();
      if (fsg && !pf) begin
        if (first == 0) first = k;
        else if (second == 0) second = k;
      end
      if (fsg && first != 0 && second == 0) width++;
      if (clkg && !pc) begin
        if (last_rise != 0 && (k - last_rise) != 4) bad_int++;
        last_rise = k;
      end
      if (!fs_pin_oe) bad_oe++;
      if (rx_fs != pf || fs_pin_out != (pf ^ inv) || rx_clk != pc) bad_fwd++;
      pf = fsg; pc = clkg;
    end
    if (!inv) begin
      chk(first == 20, "R3 first fsg edge", first, 20);
      chk(second == 40, "R3 fsg interval", second, 40);
      chk(width == 4, "R4 fsg width", width, 4);
      chk(bad_int == 0 && last_rise != 0, "R2 clkg period", bad_int, 0);
    end
    chk(bad_oe == 0, "R8 pin oe driven", bad_oe, 0);
    chk(bad_fwd == 0, inv ? "R8 R12 inverted pin drive" : "R8 rx_fs/pin follow fsg", bad_fwd, 0);
  endtask

  task automatic t_gsync;
    int bad = 0, bad_oe = 0, fire = 0;
    logic [8:0] fs_s, ck_s, rx_s;
    @(negedge clk);
    clkg_div = 8'd3; frame_per = 12'd2; resync_en = 1; fs_internal_gen = 1;
    loopback_en = 0; clk_stop = 2'b00; fs_pol_inv = 0; fs_pin_in = 0;
    do_reset();
    for (int k = 0; k < 30; k++) begin
      step();
      if (fsg) bad++;
      if (fs_pin_oe) bad_oe++;
    end
    chk(bad == 0, "R5 no fire without pin edge", bad, 0);
    @(negedge clk);
    fs_pin_in = 1'b1;
    fs_s = '0; ck_s = '0; rx_s = '0;
    for (int k = 1; k <= 8; k++) begin
      step();
      fs_s[k] = fsg; ck_s[k] = clkg; rx_s[k] = rx_fs;
      if (fs_pin_oe) bad_oe++;
    end
    chk(fs_s[8:1] == 8'b0011_1100, "R5 R4 fsg after pin edge", fs_s[8:1], 8'b0011_1100);
    chk(ck_s[6:3] == 4'b0011, "R6 clkg realigned", ck_s[6:3], 4'b0011);
    chk(rx_s[4:3] == 2'b10, "R9 rx_fs from fsg", rx_s[4:3], 2'b10);
    for (int k = 0; k < 30; k++) begin
      step();
      if (fsg) fire++;
    end
    @(negedge clk);
    fs_pin_in = 1'b0;
    for (int k = 0; k < 30; k++) begin
      step();
      if (fsg) fire++;
      if (fs_pin_oe) bad_oe++;
    end
    chk(fire == 0, "R5 held pin fires once", fire, 0);
    chk(bad_oe == 0, "R9 pin not driven", bad_oe, 0);
  endtask

  task automatic t_pin_in;
    logic [3:0] s;
    @(negedge clk);
    resync_en = 0; fs_internal_gen = 0; loopback_en = 0; clk_stop = 2'b00;
    fs_pol_inv = 1; fs_pin_in = 1;
    do_reset();
    repeat (5) step();
    chk(rx_fs == 0 && fs_pin_oe == 0, "R7 idle high pin inactive", {rx_fs, fs_pin_oe}, 0);
    @(negedge clk);
    fs_pin_in = 0;
    for (int k = 1; k <= 4; k++) begin
      step();
      s[k-1] = rx_fs;
    end
    chk(s == 4'b1100, "R7 R12 active-low pin to rx_fs", s, 4'b1100);
    @(negedge clk);
    fs_pin_in = 1;
    for (int k = 1; k <= 4; k++) begin
      step();
      s[k-1] = rx_fs;
    end
    chk(s == 4'b0011 && fs_pin_oe == 0, "R7 pin release", s, 4'b0011);
  endtask

  task automatic t_loop;
    logic [7:0] pat = 8'b1011_0010;
    int bad = 0;
    @(negedge clk);
    loopback_en = 1; fs_internal_gen = 1; resync_en = 0; clk_stop = 2'b00;
    fs_pol_inv = 0;
    do_reset();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      tx_fs = pat[i];
      step();
      if (rx_fs != pat[i] || fs_pin_oe) bad++;
    end
    chk(bad == 0, "R10 loopback rx_fs from tx_fs", bad, 0);
    @(negedge clk);
    loopback_en = 0; tx_fs = 0;
  endtask

  task automatic t_stop;
    int bad10 = 0, bad11 = 0, bad01 = 0;
    logic pc;
    @(negedge clk);
    loopback_en = 0; fs_internal_gen = 1; resync_en = 0; fs_pol_inv = 0;
    clkg_div = 8'd3; frame_per = 12'd4;
    do_reset();
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        clk_stop = m ? 2'b11 : 2'b10;
        tx_clk = i[0];
        tx_fs = i[1];
        step();
        if (rx_clk != i[0] || rx_fs != i[1] || fs_pin_oe) begin
          if (m) bad11++; else bad10++;
        end
      end
    end
    chk(bad10 == 0, "R11 clock stop 10 routing", bad10, 0);
    chk(bad11 == 0, "R11 clock stop 11 routing", bad11, 0);
    @(negedge clk);
    clk_stop = 2'b01;
    tx_clk = 1;
    step();
    pc = clkg;
    for (int i = 0; i < 12; i++) begin
      step();
      if (rx_clk != pc || !fs_pin_oe) bad01++;
      pc = clkg;
    end
    chk(bad01 == 0, "R11 clock stop 01 keeps clkg", bad01, 0);
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    t_reset();
    t_free(1'b0);
    t_free(1'b1);
    t_gsync();
    t_pin_in();
    t_loop();
    t_stop();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule